// File: doc/BRIEF.md
# Low-Battery Degrade Ladder Controller

This controller sits in the always-on domain of a battery-powered sensing device. It watches a digitized battery reading and keeps an undervoltage flag with two thresholds: the flag sets below a low threshold and clears only at or above a higher one. While the flag is set, the controller moves the device down a ladder of reduced-activity levels, one level per evaluation period. Each level adds a restriction: a trimmed LED pulse, then a slower radio sync, then serialized (non-overlapping) bursts, and at the last level a full halt of high-sensitivity capture. The level climbs back one step at a time, each step only after the battery has stayed at or above the upper threshold for a programmable number of consecutive cycles.

Each brownout (the flag going from clear to set) and each reset event reported by the switched domain produces one log record. The record holds the cause and a snapshot of LED, radio and charging activity taken in the cycle of the event. Only one write can be outstanding. Events that arrive while a write is pending, or that arrive in the same cycle as another event, are added to a saturating miss counter instead of being dropped silently. A capture request is granted only when the analog-rail power-good flag is high and capture is not halted. The level lives in always-on state, so a switched-domain reset does not change it.

Top module: `brownout_degrade_ctrl`

## Requirements
- R1: `uv_flag` becomes 1 on the clock after `vbat_code` < FALL_CODE and 0 on the clock after `vbat_code` >= RISE_CODE. Between the two thresholds it keeps its value.
- R2: A free-running evaluation tick fires once every EVAL_PERIOD cycles, counted from reset release. On each tick where `uv_flag` is 1, `degrade_level` rises by exactly one, up to a maximum of 4. It never rises at any other time.
- R3: While `uv_flag` is 0 and `vbat_code` >= RISE_CODE, a dwell count runs. When it reaches `dwell_cycles` consecutive cycles (a value of 0 counts as 1), `degrade_level` falls by one and the count restarts. Any cycle that does not meet these conditions clears the count.
- R4: `led_trim` is 1 exactly when `degrade_level` >= 1.
- R5: `sync_slow` is 1 exactly when `degrade_level` >= 2.
- R6: `burst_serial` is 1 exactly when `degrade_level` >= 3.
- R7: `capture_halt` is 1 exactly when `degrade_level` == 4. `capture_go` = `capture_req` AND `pg_ana` AND NOT `capture_halt`, combinationally.
- R8: A brownout (`vbat_code` < FALL_CODE while `uv_flag` is 0) or an `sw_rst_evt` cycle, when no write is pending, gives a one-cycle `log_wr` on the next clock. `log_data` is laid out as {cause[2:0], charging, radio_busy, led_busy}, with bit 0 = LED. The cause is 3'b100 for a brownout and {0, `sw_rst_code`} for a reset. If both events occur in the same cycle, the brownout is the one written.
- R9: A write stays pending from `log_wr` until a `log_done` cycle. Each event that is not written (because a write is pending, or because it lost to a simultaneous event) adds one to `log_miss_cnt`, which saturates at its all-ones value.
- R10: `sw_rst_evt` does not change `degrade_level`.
- R11: After reset, `degrade_level`, `uv_flag`, `log_wr`, `log_data` and `log_miss_cnt` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high always-on reset |
| vbat_code | input | VW | Digitized battery voltage |
| dwell_cycles | input | DW | Consecutive-good cycles needed per upward step |
| pg_ana | input | 1 | Analog rail power-good |
| led_busy | input | 1 | LED burst active |
| radio_busy | input | 1 | Radio burst active |
| charging | input | 1 | Charger active |
| sw_rst_evt | input | 1 | One-cycle switched-domain reset report |
| sw_rst_code | input | 2 | Reset cause code for that report |
| capture_req | input | 1 | Request to start a high-sensitivity capture |
| log_done | input | 1 | Log store finished the pending write |
| uv_flag | output | 1 | Hysteretic undervoltage flag |
| degrade_level | output | 3 | Current ladder level 0..4 |
| led_trim | output | 1 | Reduce LED pulse current/length |
| sync_slow | output | 1 | Lower radio sync rate |
| burst_serial | output | 1 | Forbid overlapping bursts |
| capture_halt | output | 1 | Stop high-sensitivity capture |
| capture_go | output | 1 | Capture grant |
| log_wr | output | 1 | Log write strobe |
| log_data | output | 6 | Log record |
| log_miss_cnt | output | CW | Saturating count of unwritten events |

## Verification
The hardest states to reach are events that collide: a second event while a write is still pending, a brownout and a reset report in the same cycle, and enough collisions to saturate the miss counter. The bench gets there by withholding `log_done` while it issues reset reports back to back, and by driving the voltage drop and a reset report in the same cycle. A second hard case is the upward dwell being interrupted. The bench makes a brief dip into the hysteresis band partway through the dwell, so the count has to start over. Every cycle is compared against a behavioural model that tracks the tick phase and the dwell count independently of the design.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

    typedef enum logic [2:0] {
        LVL_FULL      = 3'd0,
        LVL_LED_TRIM  = 3'd1,
        LVL_SYNC_SLOW = 3'd2,
        LVL_SERIAL    = 3'd3,
        LVL_HALT      = 3'd4
    } lvl_e;

    typedef struct packed {
        logic [2:0] cause;
        logic       charging;
        logic       radio;
        logic       led;
    } log_rec_t;

    localparam int unsigned LOG_W = $bits(log_rec_t);

    function automatic log_rec_t make_rec(input logic bo, input logic [1:0] code,
                                          input logic chg, input logic rad,
                                          input logic led);
        log_rec_t r;
        r.cause    = bo ? 3'b100 : {1'b0, code};
        r.charging = chg;
        r.radio    = rad;
        r.led      = led;
        return r;
    endfunction

    function automatic logic at_least(input lvl_e l, input lvl_e s);
        return l >= s;
    endfunction

endpackage

// File: rtl/bdp_uv_detect.sv
module bdp_uv_detect #(
    parameter int VW        = 8,
    parameter int FALL_CODE = 100,
    parameter int RISE_CODE = 120
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [VW-1:0] vbat,
    output logic          uv,
    output logic          bo_evt,
    output logic          above_rise
);
    localparam logic [VW-1:0] FALL_C = VW'(FALL_CODE);
    localparam logic [VW-1:0] RISE_C = VW'(RISE_CODE);

    logic below_fall;

    assign below_fall = vbat < FALL_C;
    assign above_rise = vbat >= RISE_C;
    assign bo_evt     = below_fall && !uv;

    always_ff @(posedge clk) begin
        if (rst)             uv <= 1'b0;
        else if (below_fall) uv <= 1'b1;
        else if (above_rise) uv <= 1'b0;
    end

    p_uv_set_r1: assert property (@(posedge clk) disable iff (rst)
        (vbat < FALL_C) |=> uv);
    p_uv_clear_r1: assert property (@(posedge clk) disable iff (rst)
        (vbat >= RISE_C) |=> !uv);
    p_uv_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (vbat >= FALL_C && vbat < RISE_C) |=> (uv == $past(uv)));

endmodule

// File: rtl/bdp_ladder.sv
module bdp_ladder
    import bdp_pkg::*;
#(
    parameter int EVAL_PERIOD = 8,
    parameter int DW          = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          uv,
    input  logic          above_rise,
    input  logic [DW-1:0] dwell,
    output lvl_e          level
);
    localparam int TW = $clog2(EVAL_PERIOD + 1);
    localparam logic [TW-1:0] TICK_LAST = TW'(EVAL_PERIOD - 1);

    logic [TW-1:0] tick_cnt;
    logic          tick;
    logic [DW:0]   dwell_cnt;
    logic [DW:0]   dwell_eff;
    logic          go_down;
    logic          go_up_run;
    logic          up_due;

    assign tick      = tick_cnt == TICK_LAST;
    assign dwell_eff = (dwell == '0) ? (DW+1)'(1) : {1'b0, dwell};
    assign go_down   = tick && uv && (level != LVL_HALT);
    assign go_up_run = above_rise && !uv && (level != LVL_FULL);
    assign up_due    = (dwell_cnt + (DW+1)'(1)) >= dwell_eff;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt  <= '0;
            dwell_cnt <= '0;
            level     <= LVL_FULL;
        end else begin
            tick_cnt <= tick ? '0 : tick_cnt + TW'(1);
            if (go_down) begin
                level <= lvl_e'(level + 3'd1);
            end
            if (go_up_run) begin
                if (up_due) begin
                    level     <= lvl_e'(level - 3'd1);
                    dwell_cnt <= '0;
                end else begin
                    dwell_cnt <= dwell_cnt + (DW+1)'(1);
                end
            end else begin
                dwell_cnt <= '0;
            end
        end
    end

    p_one_step_r2: assert property (@(posedge clk) disable iff (rst)
        (level > $past(level)) |-> (level == lvl_e'($past(level) + 3'd1)));
    p_down_needs_uv_r2: assert property (@(posedge clk) disable iff (rst)
        (level > $past(level)) |-> $past(uv));
    p_up_needs_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (level < $past(level)) |-> (!$past(uv) && $past(above_rise)));
    p_level_range_r2: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_HALT);

endmodule

// File: rtl/bdp_event_log.sv
module bdp_event_log
    import bdp_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bo_evt,
    input  logic          rst_evt,
    input  logic [1:0]    rst_code,
    input  logic          led,
    input  logic          radio,
    input  logic          chg,
    input  logic          done,
    output logic          log_wr,
    output log_rec_t      log_rec,
    output logic [CW-1:0] miss_cnt
);
    logic        busy;
    logic [1:0]  n_ev;
    logic        accept;
    logic [1:0]  n_miss;
    logic [CW:0] miss_sum;

    assign n_ev     = {1'b0, bo_evt} + {1'b0, rst_evt};
    assign accept   = (n_ev != 2'd0) && !busy;
    assign n_miss   = n_ev - {1'b0, accept};
    assign miss_sum = {1'b0, miss_cnt} + (CW+1)'(n_miss);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            log_wr   <= 1'b0;
            log_rec  <= '0;
            miss_cnt <= '0;
        end else begin
            log_wr <= accept;
            if (accept) begin
                log_rec <= make_rec(bo_evt, rst_code, chg, radio, led);
                busy    <= 1'b1;
            end else if (done) begin
                busy <= 1'b0;
            end
            miss_cnt <= miss_sum[CW] ? '1 : miss_sum[CW-1:0];
        end
    end

    p_wr_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        log_wr |=> !log_wr);
    p_busy_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> !log_wr);
    p_miss_mono_r9: assert property (@(posedge clk) disable iff (rst)
        miss_cnt >= $past(miss_cnt));

endmodule

// File: rtl/brownout_degrade_ctrl.sv
module brownout_degrade_ctrl
    import bdp_pkg::*;
#(
    parameter int VW          = 8,
    parameter int FALL_CODE   = 100,
    parameter int RISE_CODE   = 120,
    parameter int EVAL_PERIOD = 8,
    parameter int DW          = 8,
    parameter int CW          = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [VW-1:0] vbat_code,
    input  logic [DW-1:0] dwell_cycles,
    input  logic          pg_ana,
    input  logic          led_busy,
    input  logic          radio_busy,
    input  logic          charging,
    input  logic          sw_rst_evt,
    input  logic [1:0]    sw_rst_code,
    input  logic          capture_req,
    input  logic          log_done,
    output logic          uv_flag,
    output logic [2:0]    degrade_level,
    output logic          led_trim,
    output logic          sync_slow,
    output logic          burst_serial,
    output logic          capture_halt,
    output logic          capture_go,
    output logic          log_wr,
    output logic [5:0]    log_data,
    output logic [CW-1:0] log_miss_cnt
);
    logic     bo_evt;
    logic     above_rise;
    lvl_e     level;
    log_rec_t rec;

    bdp_uv_detect #(.VW(VW), .FALL_CODE(FALL_CODE), .RISE_CODE(RISE_CODE)) u_uv (
        .clk(clk), .rst(rst), .vbat(vbat_code),
        .uv(uv_flag), .bo_evt(bo_evt), .above_rise(above_rise)
    );

    bdp_ladder #(.EVAL_PERIOD(EVAL_PERIOD), .DW(DW)) u_ladder (
        .clk(clk), .rst(rst), .uv(uv_flag), .above_rise(above_rise),
        .dwell(dwell_cycles), .level(level)
    );

    bdp_event_log #(.CW(CW)) u_log (
        .clk(clk), .rst(rst), .bo_evt(bo_evt), .rst_evt(sw_rst_evt),
        .rst_code(sw_rst_code), .led(led_busy), .radio(radio_busy),
        .chg(charging), .done(log_done), .log_wr(log_wr),
        .log_rec(rec), .miss_cnt(log_miss_cnt)
    );

    assign degrade_level = level;
    assign led_trim      = at_least(level, LVL_LED_TRIM);
    assign sync_slow     = at_least(level, LVL_SYNC_SLOW);
    assign burst_serial  = at_least(level, LVL_SERIAL);
    assign capture_halt  = at_least(level, LVL_HALT);
    assign capture_go    = capture_req && pg_ana && !capture_halt;
    assign log_data      = rec;

    p_halt_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        capture_halt |-> !capture_go);
    p_pg_gate_r7: assert property (@(posedge clk) disable iff (rst)
        !pg_ana |-> !capture_go);
    p_ladder_nest_r6: assert property (@(posedge clk) disable iff (rst)
        burst_serial |-> (sync_slow && led_trim));

endmodule

// File: tb/brownout_degrade_ctrl_tb.sv
module brownout_degrade_ctrl_tb;

    localparam int FALL = 100;
    localparam int RISE = 120;
    localparam int EVAL = 8;
    localparam int CW   = 4;
    localparam int MISS_MAX = (1 << CW) - 1;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst = 1'b1;
    logic [7:0]    vbat_code = 8'd200;
    logic [7:0]    dwell_cycles = 8'd4;
    logic          pg_ana = 1'b1;
    logic          led_busy = 1'b0;
    logic          radio_busy = 1'b0;
    logic          charging = 1'b0;
    logic          sw_rst_evt = 1'b0;
    logic [1:0]    sw_rst_code = 2'd0;
    logic          capture_req = 1'b1;
    logic          log_done = 1'b0;
    logic          uv_flag;
    logic [2:0]    degrade_level;
    logic          led_trim, sync_slow, burst_serial, capture_halt, capture_go;
    logic          log_wr;
    logic [5:0]    log_data;
    logic [CW-1:0] log_miss_cnt;

    brownout_degrade_ctrl #(.FALL_CODE(FALL), .RISE_CODE(RISE),
                            .EVAL_PERIOD(EVAL), .CW(CW)) u_dut (
        .clk(clk), .rst(rst), .vbat_code(vbat_code), .dwell_cycles(dwell_cycles),
        .pg_ana(pg_ana), .led_busy(led_busy), .radio_busy(radio_busy),
        .charging(charging), .sw_rst_evt(sw_rst_evt), .sw_rst_code(sw_rst_code),
        .capture_req(capture_req), .log_done(log_done), .uv_flag(uv_flag),
        .degrade_level(degrade_level), .led_trim(led_trim), .sync_slow(sync_slow),
        .burst_serial(burst_serial), .capture_halt(capture_halt),
        .capture_go(capture_go), .log_wr(log_wr), .log_data(log_data),
        .log_miss_cnt(log_miss_cnt)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;
    bit auto_done = 1'b1;
    int pend = 0;

    // behavioural reference state
    int m_uv = 0, m_lvl = 0, m_phase = 0, m_dwell = 0;
    int m_busy = 0, m_wr = 0, m_data = 0, m_miss = 0;

    always @(posedge clk) begin
        int bo, nev, deff;
        if (rst) begin
            m_uv = 0; m_lvl = 0; m_phase = 0; m_dwell = 0;
            m_busy = 0; m_wr = 0; m_data = 0; m_miss = 0;
        end else begin
            bo  = (int'(vbat_code) < FALL && m_uv == 0) ? 1 : 0;
            nev = bo + int'(sw_rst_evt);
            if (m_busy == 0 && nev > 0) begin
                m_wr = 1; m_busy = 1;
                if (bo == 1) m_data = 32 + 4*int'(charging) + 2*int'(radio_busy) + int'(led_busy);
                else m_data = 8*int'(sw_rst_code) + 4*int'(charging) + 2*int'(radio_busy) + int'(led_busy);
                nev = nev - 1;
            end else begin
                m_wr = 0;
                if (log_done) m_busy = 0;
            end
            m_miss = (m_miss + nev > MISS_MAX) ? MISS_MAX : m_miss + nev;
            deff = (dwell_cycles == 0) ? 1 : int'(dwell_cycles);
            if (m_uv == 1 && m_phase == EVAL - 1 && m_lvl < 4) m_lvl = m_lvl + 1;
            if (int'(vbat_code) >= RISE && m_uv == 0 && m_lvl > 0) begin
                m_dwell = m_dwell + 1;
                if (m_dwell >= deff) begin m_lvl = m_lvl - 1; m_dwell = 0; end
            end else begin
                m_dwell = 0;
            end
            m_phase = (m_phase == EVAL - 1) ? 0 : m_phase + 1;
            if (int'(vbat_code) < FALL) m_uv = 1;
            else if (int'(vbat_code) >= RISE) m_uv = 0;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R1", "uv_flag", int'(uv_flag), m_uv);
        chk("R2 R3", "degrade_level", int'(degrade_level), m_lvl);
        chk("R4", "led_trim", int'(led_trim), (m_lvl >= 1) ? 1 : 0);
        chk("R5", "sync_slow", int'(sync_slow), (m_lvl >= 2) ? 1 : 0);
        chk("R6", "burst_serial", int'(burst_serial), (m_lvl >= 3) ? 1 : 0);
        chk("R7", "capture_halt", int'(capture_halt), (m_lvl == 4) ? 1 : 0);
        chk("R7", "capture_go", int'(capture_go),
            (capture_req && pg_ana && m_lvl < 4) ? 1 : 0);
        chk("R8", "log_wr", int'(log_wr), m_wr);
        chk("R8", "log_data", int'(log_data), m_data);
        chk("R9", "log_miss_cnt", int'(log_miss_cnt), m_miss);
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
            if (log_wr) pend = 3;
            log_done = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0 && auto_done) log_done = 1'b1;
            end
        end
    endtask

    task automatic pulse_rst(input logic [1:0] code);
        sw_rst_code = code;
        sw_rst_evt  = 1'b1;
        cyc(1);
        sw_rst_evt  = 1'b0;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int keep, m0, k;
        cyc(4);
        rst = 1'b0;
        cyc(1);
        // R11 reset state
        chk("R11", "level after reset", int'(degrade_level), 0);
        chk("R11", "uv after reset", int'(uv_flag), 0);
        chk("R11", "log_wr after reset", int'(log_wr), 0);
        chk("R11", "log_data after reset", int'(log_data), 0);
        chk("R11", "miss after reset", int'(log_miss_cnt), 0);
        cyc(20);

        // R7 power-good gate
        pg_ana = 1'b0;
        cyc(2);
        chk("R7", "capture_go with pg low", int'(capture_go), 0);
        pg_ana = 1'b1;
        cyc(2);
        chk("R7", "capture_go with pg high", int'(capture_go), 1);

        // R8 reset-event record
        led_busy = 1'b1; charging = 1'b1;
        pulse_rst(2'd2);
        chk("R8", "reset log strobe", int'(log_wr), 1);
        chk("R8", "reset record", int'(log_data), 8*2 + 4 + 1);
        cyc(6);

        // R9 event while pending write
        auto_done = 1'b0;
        pulse_rst(2'd1);
        pulse_rst(2'd3);
        chk("R9", "miss while pending", int'(log_miss_cnt), 1);
        cyc(3);
        log_done = 1'b1;
        cyc(1);
        auto_done = 1'b1;
        cyc(2);

        // brownout record and ladder
        led_busy = 1'b0; charging = 1'b0; radio_busy = 1'b1;
        vbat_code = 8'd90;
        cyc(1);
        chk("R8", "brownout strobe", int'(log_wr), 1);
        chk("R8", "brownout record", int'(log_data), 32 + 2);
        chk("R1", "uv set below fall", int'(uv_flag), 1);
        k = 0;
        while (degrade_level != 3'd4 && k < 80) begin cyc(1); k++; end
        cyc(20);
        chk("R2", "level capped at 4", int'(degrade_level), 4);
        chk("R7", "halt at level 4", int'(capture_halt), 1);

        // R1 hysteresis band keeps flag set
        vbat_code = 8'd110;
        cyc(10);
        chk("R1", "uv held inside band", int'(uv_flag), 1);

        // R3 recovery with an interrupted dwell
        vbat_code = 8'd130; dwell_cycles = 8'd5;
        cyc(4);
        vbat_code = 8'd110;
        cyc(2);
        chk("R3", "no step after broken dwell", int'(degrade_level), 4);
        vbat_code = 8'd130;
        cyc(4);
        chk("R3", "still 4 before full dwell", int'(degrade_level), 4);
        cyc(1);
        chk("R3", "first step up", int'(degrade_level), 3);
        cyc(25);
        chk("R3", "fully recovered", int'(degrade_level), 0);

        // one-cycle glitch below fall
        vbat_code = 8'd90;
        cyc(1);
        vbat_code = 8'd130;
        cyc(30);

        // R10 switched-domain reset keeps level
        vbat_code = 8'd90;
        k = 0;
        while (degrade_level != 3'd3 && k < 80) begin cyc(1); k++; end
        vbat_code = 8'd130; dwell_cycles = 8'd200;
        cyc(3);
        keep = int'(degrade_level);
        chk("R4", "led trim at 3", int'(led_trim), 1);
        chk("R5", "sync slow at 3", int'(sync_slow), 1);
        chk("R6", "serial at 3", int'(burst_serial), 1);
        pulse_rst(2'd1);
        cyc(3);
        chk("R10", "level kept over sw reset", int'(degrade_level), keep);
        cyc(4);

        // R9 simultaneous brownout and reset report
        m0 = int'(log_miss_cnt);
        vbat_code = 8'd90;
        pulse_rst(2'd2);
        chk("R8", "brownout wins tie", int'(log_data), 32 + 2);
        chk("R9", "tie counted", int'(log_miss_cnt), m0 + 1);
        cyc(6);

        // R3 zero dwell counts as one
        vbat_code = 8'd130; dwell_cycles = 8'd0;
        cyc(12);
        chk("R3", "zero dwell recovery", int'(degrade_level), 0);

        // R9 saturation
        auto_done = 1'b0;
        for (int j = 0; j < 20; j++) pulse_rst(2'd1);
        chk("R9", "miss saturates", int'(log_miss_cnt), MISS_MAX);
        log_done = 1'b1;
        cyc(1);
        auto_done = 1'b1;
        cyc(4);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule